// File: doc/BRIEF.md
# Memory-Mapped Stall Rule Monitor

This block sits passively beside a memory-mapped link between a host and an agent whose agent may stall transfers by holding a stall line high. It samples the request lines (address, byte enables, read, write, write data) and the stall line on every rising edge. It never drives the bus.

The monitor raises sticky error flags when the rules for stalled transfers are broken:

- a stalled request changes or is withdrawn before it completes;
- a stall runs longer than a configured number of cycles;
- read and write are raised together.

It also keeps saturating counts of completed reads, completed writes and stalled cycles. A one-cycle synchronous clear zeroes every flag and counter. Integration or debug logic reads the results directly from the output ports.

A request completes on the edge where it is present and the stall line is low. A request that first appears while the stall line is already high is legal. A high stall line with no request present is idle behaviour and is not counted.

Top module: `mm_stall_monitor`

## Requirements
- R1: After reset all flags and counters read zero. A cycle with `stat_clear` high zeroes all flags and counters at that edge, and this takes priority over any event in the same cycle.
- R2: Suppose edge k samples a request (read or write high) with `bus_stall` high. If edge k+1 samples any difference in address, byte enables, read, write or write data, `err_unstable` reads 1 after edge k+1. A change that follows an edge with `bus_stall` low is not flagged.
- R3: Lowering read or write while the previous edge sampled that request stalled sets `err_unstable`.
- R4: A request that begins while `bus_stall` is already high, with no stalled request at the previous edge, does not set `err_unstable`.
- R5: `num_reads` increments at each edge sampling read=1, write=0, stall=0. `num_writes` increments at each edge sampling write=1, read=0, stall=0.
- R6: `num_waits` increments at each edge sampling a request with `bus_stall` high. `bus_stall` high with neither read nor write high leaves it unchanged.
- R7: The flag `err_timeout` is set at the edge that samples the (STALL_LIMIT+1)-th consecutive stalled cycle. A run of exactly STALL_LIMIT stalled cycles does not set it.
- R8: An edge sampling read and write both high sets `err_rdwr`, and that edge counts as neither a read nor a write completion.
- R9: Each counter stops at 2^CNT_W-1 and does not wrap.
- R10: Every flag, once set, stays at 1 until a cycle with `stat_clear` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_clear | input | 1 | Synchronous clear of flags and counters |
| bus_addr | input | ADDR_W | Observed request address |
| bus_be | input | BE_W | Observed byte enables |
| bus_rd | input | 1 | Observed read request |
| bus_wr | input | 1 | Observed write request |
| bus_wdata | input | DATA_W | Observed write data |
| bus_stall | input | 1 | Observed agent stall line |
| err_unstable | output | 1 | Sticky: stalled request changed or withdrawn |
| err_timeout | output | 1 | Sticky: stall exceeded STALL_LIMIT cycles |
| err_rdwr | output | 1 | Sticky: read and write high together |
| num_reads | output | CNT_W | Saturating count of completed reads |
| num_writes | output | CNT_W | Saturating count of completed writes |
| num_waits | output | CNT_W | Saturating count of stalled request cycles |

## Verification
A stale or wrongly gated request snapshot would show as a false or missing `err_unstable` one edge after the second cycle of a stall. The bench therefore sweeps every pair of consecutive command, stall and address patterns. An off-by-one in the stall run counter is visible only at the limit boundary, so runs of exactly STALL_LIMIT and STALL_LIMIT+1 cycles are driven. Counter faults appear on the very next edge, and wrap-around appears once a small counter width is filled past its maximum.

// File: rtl/mm_mon_pkg.sv
// Package: shared indices and counts for the stall rule monitor.
// Assumes: consumers index their flag and counter arrays with these constants.
package mm_mon_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int FL_UNSTABLE = 0;
    localparam int FL_TIMEOUT  = 1;
    localparam int FL_RDWR     = 2;

    localparam int NUM_CNTRS = 3;
    localparam int CI_RD   = 0;
    localparam int CI_WR   = 1;
    localparam int CI_WAIT = 2;
endpackage

// File: rtl/mm_req_tracker.sv
// Module: mm_req_tracker
// Keeps a snapshot of the request seen at the previous edge and reports,
// combinationally for the current cycle, whether a stalled request changed.
// It also decodes completions and the illegal read-plus-write command.
// Assumes: inputs are sampled on clk; reset is synchronous, active low.
module mm_req_tracker #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stall,
    output logic              stall_now,
    output logic              unstable,
    output logic              rd_done,
    output logic              wr_done,
    output logic              rdwr
);
    localparam int SNAP_W = ADDR_W + BE_W + DATA_W + 2;

    logic [SNAP_W-1:0] cur_snap;
    logic [SNAP_W-1:0] prev_snap;
    logic              prev_stall;

    assign cur_snap  = {addr, be, rd, wr, wdata};
    assign stall_now = (rd | wr) & stall;

    // Capture the request and whether it was held off at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_snap  <= '0;
            prev_stall <= 1'b0;
        end else begin
            prev_snap  <= cur_snap;
            prev_stall <= stall_now;
        end
    end

    // Decode rule breaks and completions for the current cycle.
    always_comb begin
        unstable = prev_stall && (cur_snap != prev_snap);
        rdwr     = rd & wr;
        rd_done  = rd & ~wr & ~stall;
        wr_done  = wr & ~rd & ~stall;
    end
endmodule

// File: rtl/mm_stall_timer.sv
// Module: mm_stall_timer
// Counts consecutive stalled-request cycles and reports a timeout in the
// cycle that would make the run exceed STALL_LIMIT.
// Assumes: STALL_LIMIT >= 1; the run counter saturates one above the limit.
module mm_stall_timer #(
    parameter int STALL_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_now,
    output logic timeout
);
    localparam int RUN_W = $clog2(STALL_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(STALL_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(STALL_LIMIT);

    logic [RUN_W-1:0] run;

    // Track the length of the current stall run, restarting when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!stall_now) begin
            run <= '0;
        end else if (run != RUN_CAP) begin
            run <= run + 1'b1;
        end
    end

    // A stalled cycle after STALL_LIMIT earlier ones is a timeout.
    assign timeout = stall_now && (run >= RUN_LIM);
endmodule

// File: rtl/mm_sat_counter.sv
// Module: mm_sat_counter
// Saturating event counter with synchronous clear.
// Assumes: clear has priority over increment.
module mm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    // Count events, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && (value != MAX_VAL)) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/mm_stall_monitor.sv
// Module: mm_stall_monitor (top)
// Passive monitor of a memory-mapped link with agent stall. Holds sticky
// error flags and saturating transfer and stall counters.
// Assumes: all bus inputs are synchronous to clk; drives nothing on the bus.
module mm_stall_monitor
    import mm_mon_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BE_W        = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int STALL_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_clear,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_stall,
    output logic              err_unstable,
    output logic              err_timeout,
    output logic              err_rdwr,
    output logic [CNT_W-1:0]  num_reads,
    output logic [CNT_W-1:0]  num_writes,
    output logic [CNT_W-1:0]  num_waits
);
    logic                 stall_now;
    logic                 rd_done;
    logic                 wr_done;
    logic [NUM_FLAGS-1:0] viol;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_CNTRS-1:0] incs;
    logic [CNT_W-1:0]     cnt_val [NUM_CNTRS];

    mm_req_tracker #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W),
        .DATA_W (DATA_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .be        (bus_be),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .stall     (bus_stall),
        .stall_now (stall_now),
        .unstable  (viol[FL_UNSTABLE]),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .rdwr      (viol[FL_RDWR])
    );

    mm_stall_timer #(
        .STALL_LIMIT (STALL_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_now (stall_now),
        .timeout   (viol[FL_TIMEOUT])
    );

    assign incs[CI_RD]   = rd_done;
    assign incs[CI_WR]   = wr_done;
    assign incs[CI_WAIT] = stall_now;

    // One sticky flag per rule, cleared only by stat_clear.
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[f] <= 1'b0;
            end else if (stat_clear) begin
                flags[f] <= 1'b0;
            end else if (viol[f]) begin
                flags[f] <= 1'b1;
            end
        end
    end

    // One saturating counter per counted event.
    for (genvar c = 0; c < NUM_CNTRS; c++) begin : g_cnt
        mm_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (stat_clear),
            .inc   (incs[c]),
            .value (cnt_val[c])
        );
    end

    assign err_unstable = flags[FL_UNSTABLE];
    assign err_timeout  = flags[FL_TIMEOUT];
    assign err_rdwr     = flags[FL_RDWR];
    assign num_reads    = cnt_val[CI_RD];
    assign num_writes   = cnt_val[CI_WR];
    assign num_waits    = cnt_val[CI_WAIT];
endmodule

// File: rtl/mm_stall_monitor_chk.sv
// Module: mm_stall_monitor_chk
// Property checks on the monitor's ports, bound into every instance.
// Assumes: sees the same clock and reset as the monitor.
module mm_stall_monitor_chk #(
    parameter int ADDR_W      = 32,
    parameter int BE_W        = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int STALL_LIMIT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_clear,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_stall,
    input logic              err_unstable,
    input logic              err_timeout,
    input logic              err_rdwr,
    input logic [CNT_W-1:0]  num_reads,
    input logic [CNT_W-1:0]  num_writes,
    input logic [CNT_W-1:0]  num_waits
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic        c_pstall;
    logic [31:0] c_run;
    logic        c_stalled;

    assign c_stalled = (bus_rd | bus_wr) & bus_stall;

    // Remember whether the previous edge saw a stalled request.
    always_ff @(posedge clk) begin
        if (!rst_n) c_pstall <= 1'b0;
        else        c_pstall <= c_stalled;
    end

    // Independent stall-run length, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   c_run <= '0;
        else if (!c_stalled)          c_run <= '0;
        else if (c_run <= 32'(STALL_LIMIT)) c_run <= c_run + 1;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clear |=> (!err_unstable && !err_timeout && !err_rdwr &&
                        num_reads == '0 && num_writes == '0 && num_waits == '0));

    assert_legal_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_pstall && !err_unstable && !stat_clear) |=> !err_unstable);

    assert_read_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_stall && !stat_clear && num_reads != CMAX)
        |=> num_reads == $past(num_reads) + 1'b1);

    assert_write_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !bus_stall && !stat_clear && num_writes != CMAX)
        |=> num_writes == $past(num_writes) + 1'b1);

    assert_idle_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr && !stat_clear) |=> $stable(num_waits));

    assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_stalled && c_run >= 32'(STALL_LIMIT) && !stat_clear) |=> err_timeout);

    assert_rdwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && !stat_clear) |=> (err_rdwr && $stable(num_reads) && $stable(num_writes)));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (num_waits == CMAX && !stat_clear) |=> num_waits == CMAX);

    assert_sticky_unstable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unstable && !stat_clear) |=> err_unstable);

    assert_sticky_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !stat_clear) |=> err_timeout);

    assert_sticky_rdwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rdwr && !stat_clear) |=> err_rdwr);
endmodule

bind mm_stall_monitor mm_stall_monitor_chk #(
    .ADDR_W      (ADDR_W),
    .BE_W        (BE_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .STALL_LIMIT (STALL_LIMIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_clear   (stat_clear),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_stall    (bus_stall),
    .err_unstable (err_unstable),
    .err_timeout  (err_timeout),
    .err_rdwr     (err_rdwr),
    .num_reads    (num_reads),
    .num_writes   (num_writes),
    .num_waits    (num_waits)
);

// File: tb/test_mm_stall_monitor.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of two-cycle command/stall/address patterns plus
// directed boundary runs, compared against an arithmetic model.
module test_mm_stall_monitor;
    localparam int AW = 8;
    localparam int BW = 2;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int LIM = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stat_clear = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [BW-1:0] bus_be = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_stall = 1'b0;
    logic          err_unstable, err_timeout, err_rdwr;
    logic [CW-1:0] num_reads, num_writes, num_waits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    bit          m_stab, m_to, m_both, m_pstall;
    int          m_rd, m_wr, m_wait, m_run;
    logic [19:0] m_prev;

    always #2.5 clk = ~clk;

    mm_stall_monitor #(
        .ADDR_W(AW), .BE_W(BW), .DATA_W(DW), .CNT_W(CW), .STALL_LIMIT(LIM)
    ) i_mm_stall_monitor (
        .clk(clk), .rst_n(rst_n), .stat_clear(stat_clear),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_stall(bus_stall),
        .err_unstable(err_unstable), .err_timeout(err_timeout), .err_rdwr(err_rdwr),
        .num_reads(num_reads), .num_writes(num_writes), .num_waits(num_waits)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_stab = 0; m_to = 0; m_both = 0; m_pstall = 0;
        m_rd = 0; m_wr = 0; m_wait = 0; m_run = 0; m_prev = '0;
    endtask

    task automatic compare_all();
        chk("R2", "err_unstable", int'(err_unstable), int'(m_stab));
        chk("R7", "err_timeout", int'(err_timeout), int'(m_to));
        chk("R8", "err_rdwr", int'(err_rdwr), int'(m_both));
        chk("R5", "num_reads", int'(num_reads), m_rd);
        chk("R5", "num_writes", int'(num_writes), m_wr);
        chk("R6", "num_waits", int'(num_waits), m_wait);
    endtask

    // Drive one cycle, update the model, then compare after the edge.
    task automatic step(input bit c, input bit r, input bit w, input bit st,
                        input logic [AW-1:0] a, input logic [BW-1:0] b, input logic [DW-1:0] d);
        logic [19:0] cur;
        bit stl, viol, tov;
        @(negedge clk);
        stat_clear = c; bus_rd = r; bus_wr = w; bus_stall = st;
        bus_addr = a; bus_be = b; bus_wdata = d;
        cur  = {a, b, r, w, d};
        stl  = (r | w) & st;
        viol = m_pstall && (cur != m_prev);
        tov  = stl && (m_run >= LIM);
        if (c) begin
            m_stab = 0; m_to = 0; m_both = 0; m_rd = 0; m_wr = 0; m_wait = 0;
        end else begin
            if (viol) m_stab = 1;
            if (tov) m_to = 1;
            if (r && w) m_both = 1;
            if (r && !w && !st && m_rd < CMAX) m_rd++;
            if (w && !r && !st && m_wr < CMAX) m_wr++;
            if (stl && m_wait < CMAX) m_wait++;
        end
        m_pstall = stl;
        m_prev = cur;
        m_run = stl ? ((m_run < LIM + 1) ? m_run + 1 : m_run) : 0;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle(input bit st);
        step(1'b0, 1'b0, 1'b0, st, 8'h00, 2'b00, 8'h00);
    endtask

    task automatic clr();
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 8'h00);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "reset err_unstable", int'(err_unstable), 0);
        chk("R1", "reset err_timeout", int'(err_timeout), 0);
        chk("R1", "reset err_rdwr", int'(err_rdwr), 0);
        chk("R1", "reset counters", int'(num_reads) + int'(num_writes) + int'(num_waits), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive pairs: bit0 read, bit1 write, bit2 stall, bit3 address select
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                clr();
                step(1'b0, p[0], p[1], p[2], p[3] ? 8'h5A : 8'hA5, 2'b11, p[3] ? 8'h3C : 8'hC3);
                step(1'b0, q[0], q[1], q[2], q[3] ? 8'h5A : 8'hA5, 2'b11, q[3] ? 8'h3C : 8'hC3);
            end
        end

        // R2: byte-enable change and write-data change during a stalled write
        clr();
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'b01, 8'h77);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'b10, 8'h77);
        chk("R2", "byte enable change flagged", int'(err_unstable), 1);
        clr();
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'b01, 8'h77);
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 2'b01, 8'h78);
        chk("R2", "write data change flagged", int'(err_unstable), 1);

        // R3: withdrawn read while stalled
        clr();
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h20, 2'b11, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 2'b11, 8'h00);
        chk("R3", "dropped request flagged", int'(err_unstable), 1);

        // R4: request raised while stall already high
        clr();
        idle(1'b1);
        idle(1'b1);
        chk("R6", "idle stall not counted", int'(num_waits), 0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h30, 2'b11, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 2'b11, 8'h00);
        chk("R4", "start under stall legal", int'(err_unstable), 0);
        chk("R5", "read completes after stall", int'(num_reads), 1);
        chk("R6", "one wait counted", int'(num_waits), 1);

        // R10: flags stay set through idle cycles, R1: clear removes them
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 2'b00, 8'h00);
        repeat (5) idle(1'b0);
        chk("R10", "err_rdwr sticky", int'(err_rdwr), 1);
        clr();
        chk("R1", "clear drops err_rdwr", int'(err_rdwr), 0);

        // R1: clear wins over a same-cycle illegal command
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 2'b00, 8'h00);
        chk("R1", "clear priority over rdwr", int'(err_rdwr), 0);
        chk("R8", "rdwr not counted", int'(num_reads) + int'(num_writes), 0);

        // R7: stall of exactly LIM cycles, then LIM+1 cycles
        clr();
        for (int i = 0; i < LIM; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 2'b11, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 2'b11, 8'h00);
        chk("R7", "limit-length stall not flagged", int'(err_timeout), 0);
        clr();
        for (int i = 0; i < LIM + 1; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 2'b11, 8'h00);
        chk("R7", "over-limit stall flagged", int'(err_timeout), 1);
        idle(1'b0);
        chk("R10", "err_timeout sticky", int'(err_timeout), 1);

        // R9: saturation of all counters
        clr();
        for (int i = 0; i < CMAX + 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 2'b11, 8'h00);
        chk("R9", "num_reads saturates", int'(num_reads), CMAX);
        for (int i = 0; i < CMAX + 5; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 2'b11, 8'h00);
        chk("R9", "num_writes saturates", int'(num_writes), CMAX);
        clr();
        for (int i = 0; i < CMAX + 3; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1, 8'h03, 2'b11, 8'h00);
            step(1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 2'b11, 8'h00);
        end
        chk("R9", "num_waits saturates", int'(num_waits), CMAX);
        chk("R2", "completed requests legal", int'(err_unstable), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule